// File: doc/BRIEF.md
# Quadrature Phase Accumulator with Quarter-Wave Folding

This block is the phase engine of a direct digital synthesizer that produces sine and cosine at the same time. A 13-bit phase register advances by a frequency word on every clock and wraps modulo 8192. At an 8.192 MHz clock, a word of N gives an output of N kHz.

The frequency word arrives one bit at a time into a 14-bit staging shifter. It takes effect only when a commit strobe copies it into the working register, so the running tone keeps its frequency while a new word is being loaded. A single accumulator drives both channels. The cosine phase is the sine phase advanced by a quarter period, and it is formed by flipping and XORing the two top phase bits.

Each channel folds its phase into an 11-bit quarter-wave table address and a negative-half flag. The 7-bit magnitude that the external table returns is then turned into a signed 8-bit sample. The flag is delayed to match the table read latency before it picks the sign.

Top module: `quad_phase_accum`

## Requirements
- R1: While rstN is low, phase, the working frequency word, the staging shifter and both samples are zero. With no word committed, phase stays at 0.
- R2: On every rising clock edge out of reset, phase becomes (phase + word) mod 8192. Only the low 13 bits of the 14-bit working word matter, so a word of 8197 steps by 5.
- R3: On each edge with shiftEn high, the staging shifter moves one place toward its top and takes serIn into bit 0. A word is therefore loaded most significant bit first, in 14 shift cycles. With shiftEn low, the shifter holds its value.
- R4: An edge with setStrobe high copies the staging shifter into the working word. That same edge still advances phase by the old word, and the next edge uses the new one. Shifting alone never changes the phase step.
- R5: When setStrobe and shiftEn are high on the same edge, the committed word is the shifter content from before that shift.
- R6: sinAddr equals phase[10:0] when phase[11] is 0, and 2047 - phase[10:0] when phase[11] is 1. The sine negative flag is phase[12].
- R7: The cosine channel folds c = (phase + 2048) mod 8192 by the rule of R6. cosAddr is therefore 2047 - sinAddr at all times, and the cosine negative flag is c[12].
- R8: Each sample register loads the channel magnitude zero-extended to 8 bits when the applied flag is 0. When the flag is 1 it loads the 8-bit two's complement of that value. A magnitude of 0 gives 0, and 127 gives 0x81 when negative.
- R9: The flag applied to a magnitude is the one that belonged to the address presented TABLE_LAT clocks before the magnitude (default 1). With the default, the sample visible after edge n uses the magnitude present before edge n and the flag of the phase held after edge n-2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| serIn | input | 1 | Serial frequency-word data bit |
| shiftEn | input | 1 | Shift serIn into the staging shifter |
| setStrobe | input | 1 | Commit the staging shifter to the working word |
| sinMag | input | 7 | Sine table magnitude returned for sinAddr |
| cosMag | input | 7 | Cosine table magnitude returned for cosAddr |
| phase | output | 13 | Current accumulator phase |
| sinAddr | output | 11 | Folded quarter-wave sine address |
| cosAddr | output | 11 | Folded quarter-wave cosine address |
| sinSample | output | 8 | Signed sine sample, two's complement |
| cosSample | output | 8 | Signed cosine sample, two's complement |

## Verification
The sample properties assume that the magnitude inputs are valid on every clock, whether or not they match a real table. The bench therefore drives a magnitude on every cycle and sweeps it across the whole 0 to 127 range, including both ends. The staging-shifter properties assume that serIn is defined whenever shiftEn is high. All control inputs change only on the falling edge, so each strobe covers exactly one rising edge. Phase landing exactly on each quadrant boundary is reached with a word of 1 held for a full wrap.

// File: rtl/qpa_pkg.sv
package qpa_pkg;
  // Strobes from the load control to the phase datapath
  typedef struct packed {
    logic commit;   // copy staging word into the working frequency word
  } qpaStrobe_t;
endpackage

// File: rtl/qpa_ctrl.sv
module qpa_ctrl
  import qpa_pkg::*;
#(
  parameter int FREQ_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  logic              shiftEn,
  input  logic              setStrobe,
  output logic [FREQ_W-1:0] stageWord,
  output qpaStrobe_t        strobe
);
  logic [FREQ_W-1:0] stageReg;

  always_ff @(posedge clk) begin
    if (!rstN)        stageReg <= '0;
    else if (shiftEn) stageReg <= {stageReg[FREQ_W-2:0], serIn};
  end

  assign stageWord     = stageReg;
  assign strobe.commit = setStrobe;

  // R3
  shift_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftEn |=> stageReg[0] == $past(serIn));

  // R3
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !shiftEn |=> $stable(stageReg));
endmodule

// File: rtl/qpa_fold.sv
module qpa_fold #(
  parameter int PHASE_W = 13,
  localparam int ADDR_W = PHASE_W - 2
) (
  input  logic [PHASE_W-1:0] phaseIn,
  output logic [ADDR_W-1:0]  addr,
  output logic               neg
);
  // Second and fourth quadrants run backwards: XOR low bits with quadrant bit
  assign addr = phaseIn[ADDR_W-1:0] ^ {ADDR_W{phaseIn[ADDR_W]}};
  assign neg  = phaseIn[PHASE_W-1];
endmodule

// File: rtl/qpa_datapath.sv
module qpa_datapath
  import qpa_pkg::*;
#(
  parameter int PHASE_W   = 13,
  parameter int FREQ_W    = 14,
  parameter int MAG_W     = 7,
  parameter int TABLE_LAT = 1,
  localparam int ADDR_W   = PHASE_W - 2,
  localparam int OUT_W    = MAG_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  qpaStrobe_t         strobe,
  input  logic [FREQ_W-1:0]  stageWord,
  input  logic [MAG_W-1:0]   sinMag,
  input  logic [MAG_W-1:0]   cosMag,
  output logic [PHASE_W-1:0] phase,
  output logic [ADDR_W-1:0]  sinAddr,
  output logic [ADDR_W-1:0]  cosAddr,
  output logic [OUT_W-1:0]   sinSample,
  output logic [OUT_W-1:0]   cosSample
);
  logic [FREQ_W-1:0]  freqReg;
  logic [PHASE_W-1:0] phaseReg;

  always_ff @(posedge clk) begin
    if (!rstN)              freqReg <= '0;
    else if (strobe.commit) freqReg <= stageWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) phaseReg <= '0;
    else       phaseReg <= phaseReg + freqReg[PHASE_W-1:0];
  end

  assign phase = phaseReg;

  // Per-channel views: index 0 sine, index 1 cosine (quarter period ahead)
  logic [PHASE_W-1:0] chanPhase  [2];
  logic [MAG_W-1:0]   chanMag    [2];
  logic [ADDR_W-1:0]  chanAddr   [2];
  logic [OUT_W-1:0]   chanSample [2];

  assign chanPhase[0] = phaseReg;
  assign chanPhase[1] = {phaseReg[PHASE_W-1] ^ phaseReg[PHASE_W-2],
                         ~phaseReg[PHASE_W-2], phaseReg[PHASE_W-3:0]};
  assign chanMag[0]   = sinMag;
  assign chanMag[1]   = cosMag;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic             neg;
    logic             negD;
    logic [OUT_W-1:0] ext;
    logic [OUT_W-1:0] sampleReg;

    qpa_fold #(.PHASE_W(PHASE_W)) u_fold (
      .phaseIn(chanPhase[ch]),
      .addr   (chanAddr[ch]),
      .neg    (neg)
    );

    // Sign flag follows the table read latency
    if (TABLE_LAT == 0) begin : g_lat0
      assign negD = neg;
    end else if (TABLE_LAT == 1) begin : g_lat1
      logic negR;
      always_ff @(posedge clk) begin
        if (!rstN) negR <= 1'b0;
        else       negR <= neg;
      end
      assign negD = negR;
    end else begin : g_latN
      logic [TABLE_LAT-1:0] negPipe;
      always_ff @(posedge clk) begin
        if (!rstN) negPipe <= '0;
        else       negPipe <= {negPipe[TABLE_LAT-2:0], neg};
      end
      assign negD = negPipe[TABLE_LAT-1];
    end

    assign ext = {1'b0, chanMag[ch]};

    always_ff @(posedge clk) begin
      if (!rstN) sampleReg <= '0;
      else       sampleReg <= negD ? (~ext + 1'b1) : ext;
    end

    assign chanSample[ch] = sampleReg;

    // R8
    sample_mag_chk: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (sampleReg[OUT_W-1] ? (~sampleReg + 1'b1) : sampleReg)
               == {1'b0, $past(chanMag[ch])});
  end

  assign sinAddr   = chanAddr[0];
  assign cosAddr   = chanAddr[1];
  assign sinSample = chanSample[0];
  assign cosSample = chanSample[1];

  // R4
  freq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(freqReg));

  // R5
  freq_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> freqReg == $past(stageWord));

  // R7
  quad_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinAddr ^ cosAddr) == {ADDR_W{1'b1}});
endmodule

// File: rtl/quad_phase_accum.sv
module quad_phase_accum
  import qpa_pkg::*;
#(
  parameter int PHASE_W   = 13,
  parameter int FREQ_W    = 14,
  parameter int MAG_W     = 7,
  parameter int TABLE_LAT = 1,
  localparam int ADDR_W   = PHASE_W - 2,
  localparam int OUT_W    = MAG_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serIn,
  input  logic               shiftEn,
  input  logic               setStrobe,
  input  logic [MAG_W-1:0]   sinMag,
  input  logic [MAG_W-1:0]   cosMag,
  output logic [PHASE_W-1:0] phase,
  output logic [ADDR_W-1:0]  sinAddr,
  output logic [ADDR_W-1:0]  cosAddr,
  output logic [OUT_W-1:0]   sinSample,
  output logic [OUT_W-1:0]   cosSample
);
  logic [FREQ_W-1:0] stageWord;
  qpaStrobe_t        strobe;

  qpa_ctrl #(.FREQ_W(FREQ_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .serIn    (serIn),
    .shiftEn  (shiftEn),
    .setStrobe(setStrobe),
    .stageWord(stageWord),
    .strobe   (strobe)
  );

  qpa_datapath #(
    .PHASE_W  (PHASE_W),
    .FREQ_W   (FREQ_W),
    .MAG_W    (MAG_W),
    .TABLE_LAT(TABLE_LAT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .stageWord(stageWord),
    .sinMag   (sinMag),
    .cosMag   (cosMag),
    .phase    (phase),
    .sinAddr  (sinAddr),
    .cosAddr  (cosAddr),
    .sinSample(sinSample),
    .cosSample(cosSample)
  );
endmodule

// File: tb/tb_quad_phase_accum.sv
module tb_quad_phase_accum;
  logic        clk = 1'b0;
  logic        rstN;
  logic        serIn, shiftEn, setStrobe;
  logic [6:0]  sinMag, cosMag;
  logic [12:0] phase;
  logic [10:0] sinAddr, cosAddr;
  logic [7:0]  sinSample, cosSample;

  always #4 clk = ~clk;

  quad_phase_accum dut (
    .clk(clk), .rstN(rstN), .serIn(serIn), .shiftEn(shiftEn),
    .setStrobe(setStrobe), .sinMag(sinMag), .cosMag(cosMag),
    .phase(phase), .sinAddr(sinAddr), .cosAddr(cosAddr),
    .sinSample(sinSample), .cosSample(cosSample)
  );

  // Stimulus table: 14-bit word and the phase step it must produce
  localparam int NVEC = 7;
  localparam logic [13:0] VEC_WORD [NVEC] = '{14'd1, 14'd2048, 14'd455, 14'd3,
                                              14'd8191, 14'd16383, 14'd8197};
  localparam int VEC_STEP [NVEC] = '{1, 2048, 455, 3, 8191, 8191, 5};

  int tests = 0, fails = 0;
  bit finished = 0;
  int ph1, ph2, histValid, magCnt, boundaryHits, curStep;
  bit sweepOn = 0;
  logic [6:0] sinM1, cosM1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int foldAddr(input int p);
    return ((p >> 11) & 1) ? 2047 - (p & 2047) : (p & 2047);
  endfunction

  function automatic int signedOf(input int neg, input int m);
    return neg ? ((256 - m) & 255) : m;
  endfunction

  // One cycle: check at falling edge, then drive the next inputs
  task automatic tick(input int expStep, input bit sh, input bit b, input bit st,
                      input string tag);
    int ph, cp, cp2;
    @(negedge clk);
    ph = int'(phase);
    cp = (ph + 2048) & 8191;
    if (histValid >= 1 && expStep >= 0)
      check(((ph - ph1) & 8191) == expStep, tag, (ph - ph1) & 8191, expStep);
    if (histValid >= 1 && expStep == 1 && ph1 == 8191)
      check(ph == 0, "R2 wrap to zero", ph, 0);
    check(int'(sinAddr) == foldAddr(ph), "R6 sine fold", int'(sinAddr), foldAddr(ph));
    check(int'(cosAddr) == foldAddr(cp), "R7 cosine fold", int'(cosAddr), foldAddr(cp));
    if (sweepOn && (((ph & 2047) == 0) || ((ph & 2047) == 2047))) boundaryHits++;
    if (histValid >= 2) begin
      cp2 = (ph2 + 2048) & 8191;
      check(int'(sinSample) == signedOf((ph2 >> 12) & 1, int'(sinM1)),
            "R8 R9 sine sample", int'(sinSample), signedOf((ph2 >> 12) & 1, int'(sinM1)));
      check(int'(cosSample) == signedOf((cp2 >> 12) & 1, int'(cosM1)),
            "R8 R9 cosine sample", int'(cosSample), signedOf((cp2 >> 12) & 1, int'(cosM1)));
    end
    ph2 = ph1; ph1 = ph; histValid++;
    magCnt++;
    sinMag = 7'(magCnt); cosMag = 7'(127 - (magCnt & 127));
    sinM1 = sinMag; cosM1 = cosMag;
    shiftEn = sh; serIn = b; setStrobe = st;
  endtask

  task automatic loadWord(input logic [13:0] w);
    for (int i = 13; i >= 0; i--) tick(curStep, 1'b1, w[i], 1'b0, "R4 step held while shifting");
  endtask

  task automatic commitWord(input int newStep);
    tick(curStep, 1'b0, 1'b0, 1'b1, "R4 step before commit");
    tick(curStep, 1'b0, 1'b0, 1'b0, "R4 old step on commit edge");
    curStep = newStep;
  endtask

  initial begin
    rstN = 1'b0; serIn = 0; shiftEn = 0; setStrobe = 0;
    sinMag = 7'd9; cosMag = 7'd20; magCnt = 0; histValid = 0;
    ph1 = 0; ph2 = 0; curStep = 0; boundaryHits = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(phase == 13'd0, "R1 reset phase", int'(phase), 0);
    check(sinSample == 8'd0, "R1 reset sine sample", int'(sinSample), 0);
    check(cosSample == 8'd0, "R1 reset cosine sample", int'(cosSample), 0);
    check(cosAddr == 11'd2047, "R7 reset cosine address", int'(cosAddr), 2047);
    rstN = 1'b1;
    // R1 nothing committed: phase holds at 0
    repeat (4) tick(0, 1'b0, 1'b0, 1'b0, "R1 idle step zero");
    check(phase == 13'd0, "R1 idle phase", int'(phase), 0);

    // Table walk: R2 R3 R4
    for (int v = 0; v < NVEC; v++) begin
      loadWord(VEC_WORD[v]);
      commitWord(VEC_STEP[v]);
      repeat (6) tick(curStep, 1'b0, 1'b0, 1'b0, "R2 R3 step from table");
    end

    // R5: commit and shift together take the pre-shift word (5)
    loadWord(14'd5);
    tick(curStep, 1'b1, 1'b1, 1'b1, "R5 before combined edge");
    tick(curStep, 1'b0, 1'b0, 1'b0, "R5 combined edge old step");
    curStep = 5;
    repeat (4) tick(curStep, 1'b0, 1'b0, 1'b0, "R5 pre-shift word committed");
    // shifter now holds 11 and a plain commit exposes it
    commitWord(11);
    repeat (4) tick(curStep, 1'b0, 1'b0, 1'b0, "R5 shifted word later");

    // Full wrap with step 1: every quadrant boundary (R6 R7 R2)
    loadWord(14'd1);
    commitWord(1);
    sweepOn = 1;
    repeat (8200) tick(curStep, 1'b0, 1'b0, 1'b0, "R2 unit step");
    sweepOn = 0;
    check(boundaryHits >= 8, "R6 quadrant boundaries visited", boundaryHits, 8);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule